// File: doc/BRIEF.md
# RISC Integer ALU with Set-Less-Than Compares

This block is the purely combinational arithmetic and logic stage of a simple load/store integer datapath. Two 32-bit operands, a 5-bit shift distance, a 16-bit immediate and a 4-bit operation code go in. A 32-bit result and a flag that marks an all-zero result come out in the same cycle. An external decoder drives the operation code. Register file access, instruction decode and overflow traps live outside the block.

The operation set is small. Add and subtract wrap modulo 2^32. There are three bitwise operations: AND, OR and NOR; NOR is the only inverting one, so NOT is NOR with a zero second operand. There are three shifts whose distance is taken from the dedicated shift-amount input. Two compares return 0 or 1, one treating the operands as two's complement and one as unsigned. An upper-immediate load builds the top half of a constant. Equality branches use the zero flag of a subtract.

Top module: `risc_int_alu`

## Requirements
- R1: Code 0 (add) returns (opa_i + opb_i) mod 2^32; a carry out of bit 31 is dropped.
- R2: Code 1 (sub) returns (opa_i - opb_i) mod 2^32; when the operands are equal the result is 0 and zero_o is 1.
- R3: Code 2 (and) and code 3 (or) are bitwise; for 0x00000DC0 and 0x00003C00 they give 0x00000C00 and 0x00003DC0.
- R4: Code 4 (nor) returns ~(opa_i | opb_i); with opb_i = 0 it returns ~opa_i.
- R5: Code 5 (shift left logical) shifts opa_i left by shamt_i and fills the vacated low bits with 0; opb_i has no effect on the result.
- R6: Code 6 (shift right logical) shifts opa_i right by shamt_i and fills the vacated high bits with 0.
- R7: Code 7 (shift right arithmetic) shifts opa_i right by shamt_i and fills the vacated high bits with copies of opa_i[31].
- R8: Code 8 (signed set-less-than) returns 1 when opa_i < opb_i as two's complement numbers and 0 otherwise; 0xFFFFFFFF vs 1 gives 1.
- R9: Code 9 (unsigned set-less-than) returns 1 when opa_i < opb_i as unsigned numbers and 0 otherwise; 0xFFFFFFFF vs 1 gives 0.
- R10: Code 10 (upper-immediate load) returns imm_i in bits 31:16 and zeros in bits 15:0; imm_i = 61 gives 0x003D0000.
- R11: zero_o is 1 exactly when result_o is 0, for every operation code.
- R12: Codes 11 to 15 return 0, with zero_o set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand; also the value that shifts move |
| opb_i | input | 32 | Second operand |
| shamt_i | input | 5 | Shift distance for the three shift codes |
| imm_i | input | 16 | Immediate for the upper-immediate load |
| op_i | input | 4 | Operation code, values as listed in the requirements |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Set when result_o is all zeros |

## Verification
Each operation is tried with directed corner values and then with a stream of pseudo-random operands compared against a model in the bench. Operand pairs whose signs differ separate the signed compare from the unsigned one, while equal pairs and pairs differing only in bit 0 test the strict-less boundary and the subtract zero flag. Shift distances 0, 1, 16 and 31 on negative and positive values tell zero fill from sign fill and expose a wrong barrel stage, and a shift run with a busy second operand shows that the distance comes only from the shift-amount input. The unused codes and the upper-immediate load are driven with all-ones operands so that any leakage of an operand into the result shows up.

// File: rtl/risc_alu_pkg.sv
package risc_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SRA  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_LUI  = 4'd10
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = OP_LUI;
endpackage

// File: rtl/risc_alu_addsub.sv
module risc_alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W:0] diff_ext;
  logic [W-1:0] b_eff;

  assign b_eff   = sub_i ? ~b_i : b_i;
  assign sum_o   = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
  // borrow out of an extended subtract gives the unsigned compare
  assign diff_ext = {1'b0, a_i} - {1'b0, b_i};
  assign lt_u_o   = diff_ext[W];
  assign lt_s_o   = (a_i[W-1] ^ b_i[W-1]) ? a_i[W-1] : diff_ext[W-1];

  always_comb begin
    p_ltu_neq_r9: assert (!(lt_u_o && (a_i == b_i)))
      else $error("unsigned less-than set for equal operands");
    p_lts_sign_r8: assert (!((a_i[W-1] != b_i[W-1]) && (lt_s_o != a_i[W-1])))
      else $error("signed compare ignores sign difference");
    p_sub_self_r2: assert (!(sub_i && (a_i == b_i) && (sum_o != '0)))
      else $error("subtract of equal operands not zero");
  end
endmodule

// File: rtl/risc_alu_shift.sv
module risc_alu_shift #(
  parameter int unsigned W   = 32,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   a_i,
  input  logic [SHW-1:0] sh_i,
  input  logic           arith_i,
  output logic [W-1:0]   left_o,
  output logic [W-1:0]   right_o
);
  logic [W-1:0] lstage [SHW+1];
  logic [W-1:0] rstage [SHW+1];
  logic         fill;

  assign fill      = arith_i & a_i[W-1];
  assign lstage[0] = a_i;
  assign rstage[0] = a_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    assign lstage[k+1] = sh_i[k] ? {lstage[k][W-1-S:0], {S{1'b0}}} : lstage[k];
    assign rstage[k+1] = sh_i[k] ? {{S{fill}}, rstage[k][W-1:S]} : rstage[k];
  end

  assign left_o  = lstage[SHW];
  assign right_o = rstage[SHW];

  always_comb begin
    p_sll_fill_r5: assert (!((sh_i != '0) && left_o[0]))
      else $error("left shift did not zero-fill bit 0");
    p_srl_fill_r6: assert (!(!arith_i && (sh_i != '0) && right_o[W-1]))
      else $error("logical right shift did not zero-fill msb");
    p_sra_sign_r7: assert (!(arith_i && (right_o[W-1] != a_i[W-1])))
      else $error("arithmetic right shift lost the sign");
  end
endmodule

// File: rtl/risc_alu_logic.sv
module risc_alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] nor_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign nor_o = ~(a_i | b_i);
endmodule

// File: rtl/risc_int_alu.sv
module risc_int_alu
  import risc_alu_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned SHW   = $clog2(W)
) (
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [W-1:0]     result_o,
  output logic             zero_o
);
  localparam int unsigned LO_W = W - IMM_W;

  alu_op_e      op;
  logic [W-1:0] sum, and_r, or_r, nor_r, sl_r, sr_r;
  logic         lt_s, lt_u;

  assign op = alu_op_e'(op_i);

  risc_alu_addsub #(.W(W)) u_addsub (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .sub_i (op == OP_SUB),
    .sum_o (sum),
    .lt_s_o(lt_s),
    .lt_u_o(lt_u)
  );

  risc_alu_shift #(.W(W), .SHW(SHW)) u_shift (
    .a_i    (opa_i),
    .sh_i   (shamt_i),
    .arith_i(op == OP_SRA),
    .left_o (sl_r),
    .right_o(sr_r)
  );

  risc_alu_logic #(.W(W)) u_logic (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .and_o(and_r),
    .or_o (or_r),
    .nor_o(nor_r)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result_o = sum;
      OP_AND:         result_o = and_r;
      OP_OR:          result_o = or_r;
      OP_NOR:         result_o = nor_r;
      OP_SLL:         result_o = sl_r;
      OP_SRL, OP_SRA: result_o = sr_r;
      OP_SLT:         result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:        result_o = {{(W-1){1'b0}}, lt_u};
      OP_LUI:         result_o = {imm_i, {LO_W{1'b0}}};
      default:        result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;

  always_comb begin
    p_unused_zero_r12: assert (!((op_i > OP_LAST) && !zero_o))
      else $error("unused code produced a nonzero result");
    p_lui_shape_r10: assert (!((op == OP_LUI) &&
                               (result_o[W-1:LO_W] != imm_i || result_o[LO_W-1:0] != '0)))
      else $error("upper-immediate result malformed");
    p_cmp_bool_r8: assert (!(((op == OP_SLT) || (op == OP_SLTU)) && (result_o[W-1:1] != '0)))
      else $error("compare result wider than one bit");
    p_sub_zero_r11: assert (!((op == OP_SUB) && zero_o && (opa_i != opb_i)))
      else $error("zero flag on subtract of unequal operands");
  end
endmodule

// File: tb/risc_int_alu_bench.sv
module risc_int_alu_bench;
  logic        clk = 1'b0;
  logic [31:0] opa, opb;
  logic [4:0]  shamt;
  logic [15:0] imm;
  logic [3:0]  op;
  logic [31:0] result;
  logic        zero;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #10 clk = ~clk;

  risc_int_alu u_risc_int_alu (
    .opa_i   (opa),
    .opb_i   (opb),
    .shamt_i (shamt),
    .imm_i   (imm),
    .op_i    (op),
    .result_o(result),
    .zero_o  (zero)
  );

  function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] a,
                                         input logic [31:0] b, input logic [4:0] s,
                                         input logic [15:0] i);
    case (c)
      4'd0:    return a + b;
      4'd1:    return a - b;
      4'd2:    return a & b;
      4'd3:    return a | b;
      4'd4:    return ~(a | b);
      4'd5:    return a << s;
      4'd6:    return a >> s;
      4'd7:    return $unsigned($signed(a) >>> s);
      4'd8:    return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd9:    return (a < b) ? 32'd1 : 32'd0;
      4'd10:   return {i, 16'h0000};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // drive after a rising edge, sample on the falling edge
  task automatic apply(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] s, input logic [15:0] i);
    @(posedge clk);
    op = c; opa = a; opb = b; shamt = s; imm = i;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    n_chk++;
    if (result !== exp || zero !== (exp == 32'd0)) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got %h z=%b, expected %h z=%b",
               req, op, opa, opb, shamt, result, zero, exp, exp == 32'd0);
    end
  endtask

  task automatic run(input string req, input logic [3:0] c, input logic [31:0] a,
                     input logic [31:0] b, input logic [4:0] s, input logic [15:0] i,
                     input logic [31:0] exp);
    apply(c, a, b, s, i);
    check(req, exp);
  endtask

  task automatic t_idle;
    run("R1 R11 idle", 4'd0, 32'd0, 32'd0, 5'd0, 16'd0, 32'd0);
  endtask

  task automatic t_add;
    run("R1", 4'd0, 32'd17, 32'd25, 5'd0, 16'd0, 32'd42);
    run("R1 wrap", 4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0, 16'd0, 32'd0);
    run("R1 carry", 4'd0, 32'h8000_0000, 32'h8000_0001, 5'd0, 16'd0, 32'd1);
  endtask

  task automatic t_sub;
    run("R2 equal", 4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0, 16'd0, 32'd0);
    run("R2 wrap", 4'd1, 32'd0, 32'd1, 5'd0, 16'd0, 32'hFFFF_FFFF);
    run("R2 R11 nonzero", 4'd1, 32'd100, 32'd58, 5'd0, 16'd0, 32'd42);
  endtask

  task automatic t_logic;
    run("R3 and", 4'd2, 32'h0000_0DC0, 32'h0000_3C00, 5'd0, 16'd0, 32'h0000_0C00);
    run("R3 or", 4'd3, 32'h0000_0DC0, 32'h0000_3C00, 5'd0, 16'd0, 32'h0000_3DC0);
    run("R3 R11 and zero", 4'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 5'd0, 16'd0, 32'd0);
  endtask

  task automatic t_nor;
    run("R4 not", 4'd4, 32'h0000_3C00, 32'd0, 5'd0, 16'd0, 32'hFFFF_C3FF);
    run("R4 nor", 4'd4, 32'h0000_00F0, 32'h0000_000F, 5'd0, 16'd0, 32'hFFFF_FF00);
    run("R4 R11 nor zero", 4'd4, 32'hFFFF_0000, 32'h0000_FFFF, 5'd0, 16'd0, 32'd0);
  endtask

  task automatic t_shifts;
    run("R5 sll 0", 4'd5, 32'h8000_0001, 32'd0, 5'd0, 16'd0, 32'h8000_0001);
    run("R5 sll 4", 4'd5, 32'h0000_0013, 32'd0, 5'd4, 16'd0, 32'h0000_0130);
    run("R5 sll 31", 4'd5, 32'hFFFF_FFFF, 32'd0, 5'd31, 16'd0, 32'h8000_0000);
    run("R5 opb ignored", 4'd5, 32'h0000_0001, 32'hFFFF_FFFF, 5'd16, 16'd0, 32'h0001_0000);
    run("R6 srl 1", 4'd6, 32'h8000_0000, 32'd0, 5'd1, 16'd0, 32'h4000_0000);
    run("R6 srl 31", 4'd6, 32'hFFFF_FFFF, 32'd7, 5'd31, 16'd0, 32'h0000_0001);
    run("R7 sra neg 16", 4'd7, 32'h8000_1234, 32'd0, 5'd16, 16'd0, 32'hFFFF_8000);
    run("R7 sra neg 31", 4'd7, 32'h8000_0000, 32'd0, 5'd31, 16'd0, 32'hFFFF_FFFF);
    run("R7 sra pos", 4'd7, 32'h7000_0000, 32'd0, 5'd4, 16'd0, 32'h0700_0000);
  endtask

  task automatic t_cmp;
    run("R8 -1<1", 4'd8, 32'hFFFF_FFFF, 32'd1, 5'd0, 16'd0, 32'd1);
    run("R8 equal", 4'd8, 32'd5, 32'd5, 5'd0, 16'd0, 32'd0);
    run("R8 pos>neg", 4'd8, 32'd1, 32'h8000_0000, 5'd0, 16'd0, 32'd0);
    run("R8 by one", 4'd8, 32'h8000_0000, 32'h8000_0001, 5'd0, 16'd0, 32'd1);
    run("R9 max vs 1", 4'd9, 32'hFFFF_FFFF, 32'd1, 5'd0, 16'd0, 32'd0);
    run("R9 1 vs max", 4'd9, 32'd1, 32'hFFFF_FFFF, 5'd0, 16'd0, 32'd1);
    run("R9 equal", 4'd9, 32'h8000_0000, 32'h8000_0000, 5'd0, 16'd0, 32'd0);
  endtask

  task automatic t_lui;
    run("R10 61", 4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, 16'd61, 32'h003D_0000);
    run("R10 R11 zero imm", 4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 16'd0, 32'd0);
    run("R10 ones", 4'd10, 32'd0, 32'd0, 5'd0, 16'hFFFF, 32'hFFFF_0000);
  endtask

  task automatic t_unused;
    for (int c = 11; c < 16; c++)
      run("R12", 4'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, 16'hFFFF, 32'd0);
  endtask

  task automatic t_random;
    logic [31:0] a, b;
    for (int n = 0; n < 600; n++) begin
      seed = next_rand(seed); a = seed;
      seed = next_rand(seed); b = seed;
      // sometimes force sign-differing or equal operands
      if (n % 7 == 0) b = a;
      if (n % 5 == 0) b = {~a[31], b[30:0]};
      apply(4'(n % 11), a, b, seed[4:0], seed[20:5]);
      check("R1..R11 random", model(4'(n % 11), a, b, seed[4:0], seed[20:5]));
    end
  endtask

  initial begin
    op = 4'd0; opa = '0; opb = '0; shamt = '0; imm = '0;
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_nor();
    t_shifts();
    t_cmp();
    t_lui();
    t_unused();
    t_random();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule